// File: doc/BRIEF.md
# Blanking-Line Auxiliary Packet Scheduler

This block decides, line by line, which of fifteen stored auxiliary packets a video transmitter should send during vertical blanking. Each packet slot carries three control fields: a repeat bit, a request bit and the blanking line on which the packet is due. The block counts lines from a start-of-frame pulse. When a line begins, it marks every requested slot whose line matches as pending. It then hands pending slot indices one at a time to a downstream serializer over a valid/ready handshake.

Control writes land in a shadow copy. The shadow is copied into the working set only on the start-of-frame pulse, so a change made during a frame shows up in the next one. A slot with only its request bit set fires once, and its request bit then clears itself. A single stop input wipes every slot. The serializer builds the packet contents itself; this block only supplies the slot number.

Top module: `pkt_line_sched`

## Requirements
- R1: Slots are numbered 0 to 14. A control or line write whose `wr_slot` is 15 or above changes no slot, and no packet with index 15 or above is ever issued.
- R2: A write only updates the shadow copy. The shadow becomes active on the next `sof` pulse, so a slot enabled during a frame sends nothing in that frame and starts in the following one.
- R3: A slot with both repeat (`wr_cont`=1) and request (`wr_send`=1) set is issued exactly once in every frame, on its programmed line.
- R4: A slot with request set and repeat clear is issued in one frame only, after which its request bit clears itself. A slot with repeat set and request clear is never issued.
- R5: When several slots are due on the same line, they are issued in ascending slot index order, one index per accepted handshake.
- R6: The `sof` pulse is line 0 and each `line_pulse` adds one. After reset every slot's line field is 2, so a slot enabled by a control write alone goes out on line 2.
- R7: `stop_all` sets the repeat bit, request bit and line field of every slot to zero, and drops any pending or offered packet. A slot later enabled by a control write alone therefore goes out on line 0.
- R8: `pkt_valid` and `pkt_slot` hold steady until `pkt_ready` is seen. A due slot that is not accepted before its line ends stays pending and is issued later in the same frame. Among pending slots the lowest index goes next, whatever line each one was due on.
- R9: After reset no packet is offered (`pkt_valid`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame pulse; starts line 0 |
| line_pulse | input | 1 | Start of the next line |
| ctl_we | input | 1 | Write repeat and request bits of `wr_slot` |
| line_we | input | 1 | Write line field of `wr_slot` |
| wr_slot | input | SLOT_W | Slot index targeted by a write |
| wr_cont | input | 1 | Repeat bit value |
| wr_send | input | 1 | Request bit value |
| wr_line | input | LINE_W | Line field value |
| stop_all | input | 1 | Clear all slots |
| pkt_valid | output | 1 | A slot index is offered |
| pkt_slot | output | SLOT_W | Offered slot index, binary |
| pkt_ready | input | 1 | Serializer accepts the offered index |

## Verification
The hardest case to reach is a backlog, where slots due on different lines pile up because the serializer is stalled. The bench creates one by holding `pkt_ready` low across several lines. It enables a high-index slot on an early line and a low-index slot on a later line. It then checks that the index already offered is kept and the lower pending index follows, both after their own lines have passed. A sweep programs all fifteen slots with a mix of repeat and one-shot settings, placing several slots on each line. The expected order is computed frame by frame from a model of the shadow and active sets.

// File: rtl/pkt_line_sched.sv
module pkt_line_sched #(
  parameter int NUM_SLOTS = 15,
  parameter int LINE_W    = 6,
  parameter int DEF_LINE  = 2,
  localparam int SLOT_W   = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              line_pulse,
  input  logic              ctl_we,
  input  logic              line_we,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_cont,
  input  logic              wr_send,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              stop_all,
  output logic              pkt_valid,
  output logic [SLOT_W-1:0] pkt_slot,
  input  logic              pkt_ready
);

  logic [NUM_SLOTS-1:0] sh_cont, sh_send, ac_cont, ac_send, pend, hit, done, loadmask;
  logic [LINE_W-1:0]    sh_line [NUM_SLOTS];
  logic [LINE_W-1:0]    ac_line [NUM_SLOTS];
  logic [LINE_W-1:0]    line_q;
  logic                 scan_q;
  logic [SLOT_W-1:0]    pick;
  logic                 load, accept;

  wire wr_ok = wr_slot < SLOT_W'(NUM_SLOTS);
  assign accept = pkt_valid && pkt_ready;
  assign load   = (!pkt_valid || pkt_ready) && (|pend);

  always_ff @(posedge clk) begin
    if (!rst_n || stop_all) begin
      line_q <= '0;
      scan_q <= 1'b0;
    end else begin
      scan_q <= sof || line_pulse;
      if (sof)             line_q <= '0;
      else if (line_pulse) line_q <= line_q + 1'b1;
    end
  end

  always_comb begin
    pick = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--)
      if (pend[k]) pick = SLOT_W'(k);
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign hit[i]      = scan_q && ac_send[i] && (ac_line[i] == line_q);
    assign done[i]     = accept && (pkt_slot == SLOT_W'(i)) && !ac_cont[i];
    assign loadmask[i] = load && (pick == SLOT_W'(i));
    wire sel = wr_ok && (wr_slot == SLOT_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_cont[i] <= 1'b0;
        sh_send[i] <= 1'b0;
        sh_line[i] <= LINE_W'(DEF_LINE);
      end else if (stop_all) begin
        sh_cont[i] <= 1'b0;
        sh_send[i] <= 1'b0;
        sh_line[i] <= '0;
      end else begin
        if (ctl_we && sel) begin
          sh_cont[i] <= wr_cont;
          sh_send[i] <= wr_send;
        end else if (done[i]) begin
          sh_send[i] <= 1'b0;
        end
        if (line_we && sel) sh_line[i] <= wr_line;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || stop_all) begin
        ac_cont[i] <= 1'b0;
        ac_send[i] <= 1'b0;
        ac_line[i] <= '0;
        pend[i]    <= 1'b0;
      end else if (sof) begin
        ac_cont[i] <= sh_cont[i];
        ac_send[i] <= sh_send[i] && !done[i];
        ac_line[i] <= sh_line[i];
        pend[i]    <= 1'b0;
      end else begin
        if (done[i]) ac_send[i] <= 1'b0;
        pend[i] <= (pend[i] || hit[i]) && !loadmask[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stop_all) begin
      pkt_valid <= 1'b0;
      pkt_slot  <= '0;
    end else if (!pkt_valid || pkt_ready) begin
      pkt_valid <= |pend;
      pkt_slot  <= pick;
    end
  end

  assert_hold_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready && !stop_all) |=> (pkt_valid && $stable(pkt_slot)));

  assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_slot < SLOT_W'(NUM_SLOTS)));

  assert_stray_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !wr_ok && !stop_all && !accept) |=> ($stable(sh_send) && $stable(sh_cont)));

  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_all |=> (!pkt_valid && sh_send == '0 && sh_cont == '0 && pend == '0));

  assert_frame_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !stop_all) |=> (pend == '0));

endmodule

// File: tb/pkt_line_sched_bench.sv
module pkt_line_sched_bench;
  localparam int NS = 15;
  localparam int LW = 6;
  localparam int SW = 4;
  localparam int NL = 8;
  localparam int LINE_CYC = 24;

  logic clk = 0, rst_n = 0, sof = 0, line_pulse = 0, ctl_we = 0, line_we = 0;
  logic [SW-1:0] wr_slot = '0;
  logic wr_cont = 0, wr_send = 0, stop_all = 0, pkt_ready = 1;
  logic [LW-1:0] wr_line = '0;
  logic pkt_valid;
  logic [SW-1:0] pkt_slot;

  always #2 clk = ~clk;

  pkt_line_sched #(.NUM_SLOTS(NS), .LINE_W(LW), .DEF_LINE(2)) u_pkt_line_sched (
    .clk(clk), .rst_n(rst_n), .sof(sof), .line_pulse(line_pulse),
    .ctl_we(ctl_we), .line_we(line_we), .wr_slot(wr_slot), .wr_cont(wr_cont),
    .wr_send(wr_send), .wr_line(wr_line), .stop_all(stop_all),
    .pkt_valid(pkt_valid), .pkt_slot(pkt_slot), .pkt_ready(pkt_ready));

  int total = 0, bad = 0, cyc = 0, tb_line = 0, rdy_line = 0;
  int got_slot [64];
  int got_line [64];
  int got_n = 0;
  bit m_cont [NS], m_send [NS], a_cont [NS], a_send [NS];
  int m_line [NS], a_line [NS];

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && pkt_valid && pkt_ready && got_n < 64) begin
      got_slot[got_n] = int'(pkt_slot);
      got_line[got_n] = tb_line;
      got_n++;
    end
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_ctl(int s, bit c, bit d);
    ctl_we = 1; wr_slot = SW'(s); wr_cont = c; wr_send = d;
    tick(1);
    ctl_we = 0;
    if (s < NS) begin m_cont[s] = c; m_send[s] = d; end
  endtask

  task automatic wr_ln(int s, int l);
    line_we = 1; wr_slot = SW'(s); wr_line = LW'(l);
    tick(1);
    line_we = 0;
    if (s < NS) m_line[s] = l;
  endtask

  task automatic do_stop();
    stop_all = 1; tick(1); stop_all = 0;
    for (int s = 0; s < NS; s++) begin m_cont[s] = 0; m_send[s] = 0; m_line[s] = 0; end
  endtask

  task automatic begin_frame();
    got_n = 0;
    pkt_ready = (rdy_line == 0);
    for (int s = 0; s < NS; s++) begin a_cont[s] = m_cont[s]; a_send[s] = m_send[s]; a_line[s] = m_line[s]; end
    sof = 1; tb_line = 0; tick(1); sof = 0;
  endtask

  task automatic end_frame();
    for (int l = 0; l < NL; l++) begin
      tick(LINE_CYC);
      if (l < NL - 1) begin
        line_pulse = 1; tb_line = l + 1; tick(1); line_pulse = 0;
        if (tb_line == rdy_line) pkt_ready = 1;
      end
    end
    pkt_ready = 1;
    tick(4);
  endtask

  task automatic check_frame(string req);
    int es [64];
    int el [64];
    int en = 0;
    for (int l = 0; l < NL; l++)
      for (int s = 0; s < NS; s++)
        if (a_send[s] && a_line[s] == l) begin es[en] = s; el[en] = l; en++; end
    check(got_n == en, req, got_n, en);
    for (int k = 0; k < en && k < got_n; k++) begin
      check(got_slot[k] == es[k], req, got_slot[k], es[k]);
      check(got_line[k] == el[k], req, got_line[k], el[k]);
    end
    for (int k = 0; k < en; k++)
      if (!a_cont[es[k]]) m_send[es[k]] = 0;
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin m_cont[s] = 0; m_send[s] = 0; m_line[s] = 2; end
    tick(3);
    rst_n = 1;
    tick(1);
    check(pkt_valid == 0, "R9 idle after reset", int'(pkt_valid), 0);

    wr_ctl(7, 1, 1);
    begin_frame(); end_frame(); check_frame("R6 default line");
    check(got_n == 1 && got_line[0] == 2, "R6 line two", got_line[0], 2);

    begin_frame(); wr_ctl(9, 1, 1); wr_ln(9, 5); end_frame();
    check_frame("R2 not in current frame");
    begin_frame(); end_frame(); check_frame("R2 next frame");

    wr_ctl(15, 0, 0); wr_ln(15, 0); wr_ctl(15, 1, 1);
    begin_frame(); end_frame(); check_frame("R1 stray write");

    do_stop();
    begin_frame(); end_frame(); check_frame("R7 stopped");
    wr_ctl(1, 1, 1);
    begin_frame(); end_frame(); check_frame("R7 line cleared");
    check(got_n == 1 && got_line[0] == 0, "R7 line zero", got_line[0], 0);

    do_stop();
    for (int s = 0; s < NS; s++) begin
      wr_ln(s, (s * 3) % NL);
      if (s % 5 == 4)      wr_ctl(s, 1, 0);
      else if (s % 3 == 2) wr_ctl(s, 0, 1);
      else                 wr_ctl(s, 1, 1);
    end
    for (int f = 0; f < 3; f++) begin
      begin_frame(); end_frame(); check_frame("R3 R4 R5 sweep");
    end

    do_stop();
    wr_ctl(5, 1, 1); wr_ln(5, 1);
    wr_ctl(3, 1, 1); wr_ln(3, 3);
    rdy_line = 4;
    begin_frame(); end_frame();
    rdy_line = 0;
    check(got_n == 2, "R8 backlog count", got_n, 2);
    check(got_slot[0] == 5, "R8 held offer first", got_slot[0], 5);
    check(got_slot[1] == 3, "R8 pending follows", got_slot[1], 3);
    check(got_line[1] >= 4, "R8 after its line", got_line[1], 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule